// File: doc/BRIEF.md
# Watchdog Timer with Halt-Aware Reset Requests

The block is a watchdog for a small microcontroller core. It takes one of three tick sources, chosen by a configuration option, and counts them toward a time-out. The sources are a free-running dedicated oscillator tick, the instruction-clock tick and a real-time oscillator tick. All ticks arrive as single-cycle enable pulses on the block clock.

The count runs through a two-stage chain: a prescaler of `PRE_W` bits feeds a watchdog counter of `CNT_W` bits. When the counter wraps on a prescaler carry, the block requests a reset. If the core is running, it requests a full chip reset and sets a time-out flag. If the core is halted, it requests a warm reset, which clears only the program counter and stack pointer in the core. A software clear empties only the counter stage. Because of this, the interval from a clear to the next time-out lies between 2^(PRE_W+CNT_W) − 2^PRE_W + 1 and 2^(PRE_W+CNT_W) ticks.

A controller state machine has these states:
- ST_OFF: disabled by option.
- ST_RUN: watching a running core.
- ST_HALT: watching a halted core.
- ST_CHIP: the one-cycle chip-reset request.
- ST_WARM: the one-cycle warm-reset request.

Its transitions are:
- disable: any state to ST_OFF when the enable is low.
- arm: ST_OFF to ST_RUN or ST_HALT when enabled.
- sleep and wake: between ST_RUN and ST_HALT, following the halt input.
- fire_chip: to ST_CHIP on an overflow while not halted.
- fire_warm: to ST_WARM on an overflow while halted.
- settle: ST_CHIP or ST_WARM back to ST_RUN or ST_HALT.

Top module: `wdt_guard`

## Requirements
- R1: `src_sel` encodes the tick source as follows: 0 is the dedicated oscillator tick, 1 is the instruction-clock tick, 2 is the real-time tick and 3 is no source. While `src_sel` is 3, the chain does not advance.
- R2: Starting from an empty chain, the 2^(PRE_W+CNT_W)-th counted tick causes an overflow and empties the chain. The request for that overflow is high during the clock cycle that follows the edge at which the tick is counted.
- R3: `wdt_clr` empties the counter stage but leaves the prescaler running. A tick that arrives in the same cycle as the clear still advances the prescaler, but its carry is dropped.
- R4: An overflow while `halted` is 0 raises `chip_rst_req` for exactly one cycle and sets `to_flag` at the same edge.
- R5: An overflow while `halted` is 1 raises `warm_rst_req` for exactly one cycle and does not set `to_flag`.
- R6: While the instruction-clock source is selected and `halted` is 1, instruction ticks are ignored and the chain holds its value.
- R7: While the dedicated-oscillator or real-time source is selected, ticks are counted whether or not the core is halted.
- R8: While `wdt_en` is 0, the chain is held empty and no reset request is raised. `wdt_clr` and `to_clr` have no effect, so `to_flag` keeps its value.
- R9: `to_flag` is cleared by `wdt_clr` or `to_clr` while the block is enabled. If a chip-reset overflow falls in the same cycle, setting the flag wins.
- R10: Any change of `src_sel` empties the whole chain at the next edge. A tick in that cycle is not counted.
- R11: After reset, `chip_rst_req`, `warm_rst_req` and `to_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-on reset |
| wdt_en | input | 1 | Enable option; 0 disables the watchdog |
| src_sel | input | 2 | Tick source select (R1 encoding) |
| halted | input | 1 | Core halt indication |
| osc_tick | input | 1 | Dedicated oscillator tick pulse |
| instr_tick | input | 1 | Instruction-clock tick pulse |
| rtc_tick | input | 1 | Real-time oscillator tick pulse |
| wdt_clr | input | 1 | Software watchdog clear strobe |
| to_clr | input | 1 | Software time-out flag clear strobe |
| chip_rst_req | output | 1 | One-cycle full chip reset request |
| warm_rst_req | output | 1 | One-cycle warm reset request |
| to_flag | output | 1 | Sticky time-out status flag |

## Verification
The hardest situation to reach from the ports is a clear that lands with the prescaler part-way through its cycle. A correct design must then time out after fewer than 2^(PRE_W+CNT_W) ticks, and the exact count depends on the prescaler phase, which is never visible. The bench drives a known number of ticks and then clears. It expects the overflow precisely 2^(PRE_W+CNT_W) − (ticks mod 2^PRE_W) ticks later, and checks that no request appears one tick earlier. A behavioural model that tracks total ticks as an integer confirms every output on every clock, including the frozen count under halt with the instruction clock and the chain reset on a source change.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

    typedef enum logic [1:0] {
        SRC_OSC   = 2'd0,
        SRC_INSTR = 2'd1,
        SRC_RTC   = 2'd2,
        SRC_NONE  = 2'd3
    } wdt_src_e;

    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_RUN  = 3'd1,
        ST_HALT = 3'd2,
        ST_CHIP = 3'd3,
        ST_WARM = 3'd4
    } wdt_state_e;

    localparam int NUM_SRC = 4;

endpackage

// File: rtl/wdt_tick_sel.sv
module wdt_tick_sel
    import wdt_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src_sel,
    input  logic       halted,
    input  logic       osc_tick,
    input  logic       instr_tick,
    input  logic       rtc_tick,
    output logic       tick,
    output logic       src_chg
);

    logic [NUM_SRC-1:0] src_vec;
    logic [1:0]         src_q;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        if (g == int'(SRC_OSC)) begin : g_osc
            assign src_vec[g] = osc_tick;
        end else if (g == int'(SRC_INSTR)) begin : g_instr
            // instruction clock stops with the core
            assign src_vec[g] = instr_tick & ~halted;
        end else if (g == int'(SRC_RTC)) begin : g_rtc
            assign src_vec[g] = rtc_tick;
        end else begin : g_none
            assign src_vec[g] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= 2'd0;
        end else begin
            src_q <= src_sel;
        end
    end

    assign src_chg = (src_sel != src_q);
    assign tick    = src_vec[src_sel];

    AST_NONE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == SRC_NONE) |-> !tick); // R1

endmodule

// File: rtl/wdt_chain.sv
module wdt_chain #(
    parameter int PRE_W = 8,
    parameter int CNT_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic                   restart,
    input  logic                   clr,
    input  logic                   tick,
    output logic                   ovf,
    output logic [PRE_W+CNT_W-1:0] level
);

    localparam logic [PRE_W-1:0] PRE_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pre_carry;

    assign pre_carry = tick && (pre_q == PRE_MAX);
    assign ovf       = en && !restart && !clr && pre_carry && (cnt_q == CNT_MAX);
    assign level     = {cnt_q, pre_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (!en || restart) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else begin
            if (tick) begin
                pre_q <= pre_q + 1'b1;
            end
            if (clr) begin
                cnt_q <= '0;
            end else if (pre_carry) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_OVF_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (level == '0)); // R2

    AST_CLR_KEEPS_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !restart && clr) |=> (cnt_q == '0) && (pre_q == $past(pre_q) + $past({{(PRE_W-1){1'b0}}, tick}))); // R3

    AST_RESTART_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (en && restart) |=> (level == '0)); // R10

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
    import wdt_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic halted,
    input  logic ovf,
    input  logic wdt_clr,
    input  logic to_clr,
    output logic chip_rst_req,
    output logic warm_rst_req,
    output logic to_flag
);

    wdt_state_e state_q, state_d;
    wdt_state_e park;
    logic       to_q;

    assign park = halted ? ST_HALT : ST_RUN;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                state_d = en ? park : ST_OFF;
            end
            ST_RUN, ST_HALT, ST_CHIP, ST_WARM: begin
                if (!en) begin
                    state_d = ST_OFF;
                end else if (ovf) begin
                    state_d = halted ? ST_WARM : ST_CHIP;
                end else begin
                    state_d = park;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_comb begin
        chip_rst_req = 1'b0;
        warm_rst_req = 1'b0;
        unique case (state_q)
            ST_CHIP: chip_rst_req = 1'b1;
            ST_WARM: warm_rst_req = 1'b1;
            default: begin
                chip_rst_req = 1'b0;
                warm_rst_req = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            to_q <= 1'b0;
        end else if (en) begin
            if (ovf && !halted) begin
                to_q <= 1'b1;
            end else if (wdt_clr || to_clr) begin
                to_q <= 1'b0;
            end
        end
    end

    assign to_flag = to_q;

    AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !(chip_rst_req && warm_rst_req)); // R4

    AST_CHIP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst_req |=> !chip_rst_req); // R4

    AST_TO_WITH_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst_req |-> to_flag); // R4

    AST_WARM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst_req |=> !warm_rst_req); // R5

    AST_TO_ONLY_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(to_flag) |-> chip_rst_req); // R5

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!chip_rst_req && !warm_rst_req && $stable(to_flag))); // R8

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
    import wdt_guard_pkg::*;
#(
    parameter int PRE_W = 8,
    parameter int CNT_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wdt_en,
    input  logic [1:0] src_sel,
    input  logic       halted,
    input  logic       osc_tick,
    input  logic       instr_tick,
    input  logic       rtc_tick,
    input  logic       wdt_clr,
    input  logic       to_clr,
    output logic       chip_rst_req,
    output logic       warm_rst_req,
    output logic       to_flag
);

    localparam int LVL_W = PRE_W + CNT_W;

    logic             tick;
    logic             src_chg;
    logic             ovf;
    logic [LVL_W-1:0] level;

    wdt_tick_sel u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_sel    (src_sel),
        .halted     (halted),
        .osc_tick   (osc_tick),
        .instr_tick (instr_tick),
        .rtc_tick   (rtc_tick),
        .tick       (tick),
        .src_chg    (src_chg)
    );

    wdt_chain #(
        .PRE_W (PRE_W),
        .CNT_W (CNT_W)
    ) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (wdt_en),
        .restart (src_chg),
        .clr     (wdt_clr),
        .tick    (tick),
        .ovf     (ovf),
        .level   (level)
    );

    wdt_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (wdt_en),
        .halted       (halted),
        .ovf          (ovf),
        .wdt_clr      (wdt_clr),
        .to_clr       (to_clr),
        .chip_rst_req (chip_rst_req),
        .warm_rst_req (warm_rst_req),
        .to_flag      (to_flag)
    );

    AST_INSTR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_en && halted && src_sel == SRC_INSTR && !src_chg && !wdt_clr) |=> $stable(level)); // R6

    AST_OFF_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !wdt_en |=> (level == '0)); // R8

endmodule

// File: tb/wdt_guard_tb.sv
module wdt_guard_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int P    = 3;
    localparam int C    = 3;
    localparam int FULL = 1 << (P + C);
    localparam int PRE  = 1 << P;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wdt_en;
    logic [1:0] src_sel;
    logic       halted;
    logic       osc_tick, instr_tick, rtc_tick;
    logic       wdt_clr, to_clr;
    logic       chip_rst_req, warm_rst_req, to_flag;

    int    checks = 0;
    int    errors = 0;
    int    n_chip = 0;
    int    n_warm = 0;
    string cur_req = "R11";

    int m_ticks;
    int m_prev;
    bit exp_chip, exp_warm, exp_to;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_guard #(.PRE_W(P), .CNT_W(C)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .wdt_en       (wdt_en),
        .src_sel      (src_sel),
        .halted       (halted),
        .osc_tick     (osc_tick),
        .instr_tick   (instr_tick),
        .rtc_tick     (rtc_tick),
        .wdt_clr      (wdt_clr),
        .to_clr       (to_clr),
        .chip_rst_req (chip_rst_req),
        .warm_rst_req (warm_rst_req),
        .to_flag      (to_flag)
    );

    // behavioural model: total ticks held as one integer
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ticks  = 0;
            m_prev   = 0;
            exp_chip = 0;
            exp_warm = 0;
            exp_to   = 0;
        end else begin
            bit chg, tk, ov;
            int s;
            s   = int'(src_sel);
            chg = (s != m_prev);
            m_prev = s;
            case (s)
                0: tk = osc_tick;
                1: tk = instr_tick && !halted;
                2: tk = rtc_tick;
                default: tk = 0;
            endcase
            ov = 0;
            if (!wdt_en) begin
                m_ticks = 0;
            end else if (chg) begin
                m_ticks = 0;
            end else if (wdt_clr) begin
                m_ticks = ((m_ticks % PRE) + (tk ? 1 : 0)) % PRE;
            end else if (tk) begin
                m_ticks = m_ticks + 1;
                if (m_ticks == FULL) begin
                    m_ticks = 0;
                    ov = 1;
                end
            end
            exp_chip = ov && !halted;
            exp_warm = ov && halted;
            if (wdt_en) begin
                if (exp_chip) exp_to = 1;
                else if (wdt_clr || to_clr) exp_to = 0;
            end
        end
    end

    task automatic check_eq(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        check_eq(cur_req, chip_rst_req, exp_chip, "chip_rst_req vs model");
        check_eq(cur_req, warm_rst_req, exp_warm, "warm_rst_req vs model");
        check_eq(cur_req, to_flag, exp_to, "to_flag vs model");
        if (chip_rst_req) n_chip++;
        if (warm_rst_req) n_warm++;
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_ticks(int which, int n);
        case (which)
            0: osc_tick = 1;
            1: instr_tick = 1;
            default: rtc_tick = 1;
        endcase
        step(n);
        osc_tick = 0; instr_tick = 0; rtc_tick = 0;
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int c0, w0;
        rst_n = 0; wdt_en = 1; src_sel = 2'd0; halted = 0;
        osc_tick = 0; instr_tick = 0; rtc_tick = 0; wdt_clr = 0; to_clr = 0;
        step(3);
        cur_req = "R11";
        check_eq("R11", {chip_rst_req, warm_rst_req, to_flag}, 0, "outputs in reset");
        rst_n = 1;
        step(2);
        check_eq("R11", {chip_rst_req, warm_rst_req, to_flag}, 0, "outputs after reset");

        // R2 / R4: full window from empty chain
        cur_req = "R2";
        pulse_ticks(0, FULL - 1);
        step(2);
        check_eq("R2", n_chip, 0, "no request one tick early");
        pulse_ticks(0, 1);
        step(1);
        check_eq("R4", n_chip, 1, "chip request after full window");
        check_eq("R4", to_flag, 1, "to_flag set by chip reset");
        step(2);
        check_eq("R4", n_chip, 1, "chip request single cycle");

        // R3 / R9: clear with prescaler mid-cycle
        cur_req = "R3";
        pulse_ticks(0, 20);
        wdt_clr = 1; step(1); wdt_clr = 0;
        check_eq("R9", to_flag, 0, "wdt_clr clears to_flag");
        pulse_ticks(0, FULL - (20 % PRE) - 1);
        step(1);
        check_eq("R3", n_chip, 1, "no request before shortened window");
        pulse_ticks(0, 1);
        step(1);
        check_eq("R3", n_chip, 2, "request after shortened window");

        // R9: status clear strobe
        cur_req = "R9";
        to_clr = 1; step(1); to_clr = 0;
        step(1);
        check_eq("R9", to_flag, 0, "to_clr clears to_flag");

        // R5 / R7: halted, real-time source keeps counting
        cur_req = "R5";
        halted = 1; src_sel = 2'd2;
        step(2);
        w0 = n_warm; c0 = n_chip;
        pulse_ticks(2, FULL);
        step(2);
        check_eq("R7", n_warm, w0 + 1, "rtc counts while halted");
        check_eq("R5", n_chip, c0, "no chip request while halted");
        check_eq("R5", to_flag, 0, "warm reset leaves to_flag");

        // R6: instruction clock frozen under halt
        cur_req = "R6";
        src_sel = 2'd1;
        step(2);
        w0 = n_warm;
        pulse_ticks(1, 3 * FULL);
        step(1);
        check_eq("R6", n_warm, w0, "instr ticks ignored while halted");
        halted = 0;
        step(1);
        pulse_ticks(1, FULL - 1);
        step(1);
        check_eq("R6", n_chip, c0, "chain held during halt");
        pulse_ticks(1, 1);
        step(1);
        check_eq("R6", n_chip, c0 + 1, "counting resumes after wake");

        // R8: disabled
        cur_req = "R8";
        wdt_en = 0;
        step(1);
        c0 = n_chip;
        pulse_ticks(1, 2 * FULL);
        to_clr = 1; wdt_clr = 1; step(1); to_clr = 0; wdt_clr = 0;
        step(1);
        check_eq("R8", to_flag, 1, "clears ignored while disabled");
        check_eq("R8", n_chip + n_warm, c0 + w0, "no request while disabled");
        wdt_en = 1;
        step(1);
        pulse_ticks(1, FULL - 1);
        step(1);
        check_eq("R8", n_chip, c0, "chain empty after disable");
        pulse_ticks(1, 1);
        step(1);
        check_eq("R8", n_chip, c0 + 1, "request after re-enable window");

        // R10: source change empties chain
        cur_req = "R10";
        pulse_ticks(1, 40);
        src_sel = 2'd0;
        step(1);
        pulse_ticks(0, FULL - 1);
        step(1);
        check_eq("R10", n_chip, c0 + 1, "old partial count dropped");
        pulse_ticks(0, 1);
        step(1);
        check_eq("R10", n_chip, c0 + 2, "full window from switch");

        // R1: no-source code
        cur_req = "R1";
        src_sel = 2'd3;
        step(1);
        osc_tick = 1; instr_tick = 1; rtc_tick = 1;
        step(2 * FULL);
        osc_tick = 0; instr_tick = 0; rtc_tick = 0;
        step(1);
        check_eq("R1", n_chip, c0 + 2, "source code 3 does not count");
        src_sel = 2'd0;
        step(1);
        pulse_ticks(0, FULL);
        step(1);
        check_eq("R1", n_chip, c0 + 3, "source code 0 counts osc ticks");

        step(3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule